// File: doc/BRIEF.md
# Add-With-Carry-Out Execute Slice

This block executes one fixed-point instruction: a 32-bit register-to-register addition that also reports its carry out. Each cycle it takes an instruction word and a valid strobe. If the word decodes as the add-with-carry-out operation, the block reads two source registers from an internal 32-entry register file. On the next rising clock edge it writes their 32-bit sum to the target register. On the same edge it updates a three-bit exception status (carry, overflow, sticky summary overflow) and a four-bit condition field.

Two bits of the instruction select the status side effects. The carry flag is written by every accepted instruction. The overflow-enable bit controls whether the overflow and summary-overflow flags change. The record-enable bit controls whether the condition field is written. A valid word that does not decode as this instruction raises the illegal flag and leaves all state untouched.

Test access ports preload any register and the exception status. A read port and two status outputs bring the state back out. If a preload and an accepted instruction update the same state in one cycle, the preload wins.

Top module: `addc_exec_unit`

## Requirements
- R1: The instruction word is accepted when bits [31:26] equal 31 and bits [9:1] equal 10. Within the word, the target index is [25:21], source A is [20:16], source B is [15:11], overflow-enable is bit [10] and record-enable is bit [0].
- R2: On the clock edge after an accepted instruction, the target register holds the low 32 bits of source A plus source B.
- R3: Every accepted instruction writes status_flags[0] (carry) with the unsigned carry out of the 32-bit addition.
- R4: When overflow-enable is 1, status_flags[1] (overflow) is set to the signed two's-complement overflow of the addition.
- R5: Summary overflow, status_flags[2], is sticky. With overflow-enable 1 it becomes its old value ORed with the new overflow. Only the status preload port or reset can clear it.
- R6: When overflow-enable is 0, the overflow and summary-overflow flags keep their values.
- R7: When record-enable is 1, cond_bits[3] (less than), cond_bits[2] (greater than) and cond_bits[1] (equal) are written from a signed comparison of the result with zero. Exactly one of the three is set.
- R8: When record-enable is 1, cond_bits[0] receives the summary overflow value that includes this instruction's own update.
- R9: When record-enable is 0, cond_bits is unchanged.
- R10: A valid word that fails the R1 decode drives illegal high in the same cycle. It writes no register, no status flag and no condition bit.
- R11: A synchronous active-low reset clears status_flags and cond_bits.
- R12: A register preload writes the given register on the next edge. A status preload writes status_flags on the next edge. rd_data shows register rd_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present |
| instr_word | input | 32 | Instruction word |
| illegal | output | 1 | Valid word failed decode |
| gpr_load_en | input | 1 | Register preload strobe |
| gpr_load_idx | input | 5 | Register preload index |
| gpr_load_data | input | 32 | Register preload value |
| stat_load_en | input | 1 | Status preload strobe |
| stat_load_data | input | 3 | Status preload value {so, ov, ca} |
| rd_idx | input | 5 | Register read-back index |
| rd_data | output | 32 | Register read-back value |
| status_flags | output | 3 | {summary overflow, overflow, carry} |
| cond_bits | output | 4 | {lt, gt, eq, so} |

## Verification
The illegal flag is combinational, so the bench samples it in the same cycle, at the falling edge after the word is driven. The register write, the flags and the condition field all appear one rising edge after the instruction. The bench therefore waits for that edge, then reads the target register, status_flags and cond_bits at the following falling edge. That result is compared with a bench model that was updated for the same instruction. Because inputs change and outputs are read only at falling edges, no check ever looks at a value in the middle of an update.

// File: rtl/addc_pkg.sv
// Package: shared widths and encoding constants for the add-carrying slice.
// Assumes MSB-first field numbering is mapped onto [31:0] with bit 0 at [31].
package addc_pkg;
    localparam int WORD_W  = 32;
    localparam int REG_NUM = 32;
    localparam int IDX_W   = $clog2(REG_NUM);
    localparam logic [5:0] PRIMARY_OP  = 6'd31;
    localparam logic [8:0] EXTENDED_OP = 9'd10;

    typedef struct packed {
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
        logic             ovf_en;
        logic             rec_en;
    } instr_fields_t;
endpackage

// File: rtl/addc_decode.sv
// Module: addc_decode
// Splits the instruction word into its fields and tests the two opcode fields.
// Assumes a 32-bit word; purely combinational.
module addc_decode
    import addc_pkg::*;
(
    input  logic [31:0]   word,
    input  logic          valid,
    output instr_fields_t fields,
    output logic          accept,
    output logic          bad
);
    logic op_match;

    // Extract fields and compare opcodes.
    always_comb begin
        fields.dst    = word[25:21];
        fields.src_a  = word[20:16];
        fields.src_b  = word[15:11];
        fields.ovf_en = word[10];
        fields.rec_en = word[0];
        op_match      = (word[31:26] == PRIMARY_OP) && (word[9:1] == EXTENDED_OP);
        accept        = valid && op_match;
        bad           = valid && !op_match;
    end
endmodule

// File: rtl/addc_adder.sv
// Module: addc_adder
// W-bit adder reporting unsigned carry out and signed overflow.
// The carry into the top bit is produced separately so overflow is the
// xor of carry-in and carry-out of the sign position.
module addc_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         overflow
);
    logic [W-1:0] low_sum;
    logic         carry_into_msb;
    logic         msb_sum;

    // Add the low bits, then the sign bit with its incoming carry.
    always_comb begin
        low_sum        = {1'b0, op_a[W-2:0]} + {1'b0, op_b[W-2:0]};
        carry_into_msb = low_sum[W-1];
        msb_sum        = op_a[W-1] ^ op_b[W-1] ^ carry_into_msb;
        carry_out      = (op_a[W-1] & op_b[W-1]) |
                         ((op_a[W-1] ^ op_b[W-1]) & carry_into_msb);
        overflow       = carry_into_msb ^ carry_out;
        sum            = {msb_sum, low_sum[W-2:0]};
    end
endmodule

// File: rtl/addc_regfile.sv
// Module: addc_regfile
// Register file with two combinational instruction read ports, one read-back
// port and one write port shared by the instruction and the preload path.
// A preload takes priority over an instruction write. Contents are not reset.
module addc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic [IW-1:0] rc_idx,
    output logic [W-1:0]  rc_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data
);
    logic [W-1:0] regs [N];

    // Each entry is written by the preload first, else by the instruction.
    for (genvar g = 0; g < N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (ld_en && ld_idx == IW'(g))
                regs[g] <= ld_data;
            else if (wr_en && wr_idx == IW'(g))
                regs[g] <= wr_data;
        end
    end

    // Combinational reads.
    always_comb begin
        ra_data = regs[ra_idx];
        rb_data = regs[rb_idx];
        rc_data = regs[rc_idx];
    end
endmodule

// File: rtl/addc_status.sv
// Module: addc_status
// Holds the exception flags {so, ov, ca} and the condition field
// {lt, gt, eq, so}. Carry is always written by an accepted instruction;
// ov/so only when ovf_en; the condition field only when rec_en.
// A status preload wins over the instruction. Synchronous active-low reset.
module addc_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic         ovf_en,
    input  logic         rec_en,
    input  logic         ca_in,
    input  logic         ov_in,
    input  logic [W-1:0] result,
    input  logic         ld_en,
    input  logic [2:0]   ld_data,
    output logic [2:0]   flags,
    output logic [3:0]   cond
);
    logic so_next;
    logic lt_n, gt_n, eq_n;

    // Next summary overflow and signed compare with zero.
    always_comb begin
        so_next = ovf_en ? (flags[2] | ov_in) : flags[2];
        lt_n    = result[W-1];
        eq_n    = (result == '0);
        gt_n    = !lt_n && !eq_n;
    end

    // Exception flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= 3'b000;
        else if (ld_en)
            flags <= ld_data;
        else if (upd) begin
            flags[0] <= ca_in;
            if (ovf_en) begin
                flags[1] <= ov_in;
                flags[2] <= so_next;
            end
        end
    end

    // Condition field register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cond <= 4'b0000;
        else if (upd && rec_en)
            cond <= {lt_n, gt_n, eq_n, so_next};
    end

    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && !ld_en) |=> flags[2]); // R5
    AST_OE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !ovf_en && !ld_en) |=> $stable(flags[2:1])); // R6
    AST_REC_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(upd && rec_en)) |=> $stable(cond)); // R9
    AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && rec_en) |=> $onehot(cond[3:1])); // R7
    AST_COND_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && rec_en && !ld_en) |=> (cond[0] == flags[2])); // R8
endmodule

// File: rtl/addc_exec_unit.sv
// Module: addc_exec_unit
// Single-cycle execute slice for the add-with-carry-out instruction.
// Decode, register read and add are combinational; the register write and
// all flag updates happen on the next rising edge. Preload ports serve test.
module addc_exec_unit
    import addc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              illegal,
    input  logic              gpr_load_en,
    input  logic [IDX_W-1:0]  gpr_load_idx,
    input  logic [WORD_W-1:0] gpr_load_data,
    input  logic              stat_load_en,
    input  logic [2:0]        stat_load_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [2:0]        status_flags,
    output logic [3:0]        cond_bits
);
    instr_fields_t     fld;
    logic              fire;
    logic [WORD_W-1:0] opa, opb, sum;
    logic              carry, ovf;

    addc_decode u_dec (
        .word   (instr_word),
        .valid  (instr_valid),
        .fields (fld),
        .accept (fire),
        .bad    (illegal)
    );

    addc_regfile #(.W(WORD_W), .N(REG_NUM)) u_rf (
        .clk     (clk),
        .ra_idx  (fld.src_a),
        .ra_data (opa),
        .rb_idx  (fld.src_b),
        .rb_data (opb),
        .rc_idx  (rd_idx),
        .rc_data (rd_data),
        .wr_en   (fire),
        .wr_idx  (fld.dst),
        .wr_data (sum),
        .ld_en   (gpr_load_en),
        .ld_idx  (gpr_load_idx),
        .ld_data (gpr_load_data)
    );

    addc_adder #(.W(WORD_W)) u_add (
        .op_a      (opa),
        .op_b      (opb),
        .sum       (sum),
        .carry_out (carry),
        .overflow  (ovf)
    );

    addc_status #(.W(WORD_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (fire),
        .ovf_en  (fld.ovf_en),
        .rec_en  (fld.rec_en),
        .ca_in   (carry),
        .ov_in   (ovf),
        .result  (sum),
        .ld_en   (stat_load_en),
        .ld_data (stat_load_data),
        .flags   (status_flags),
        .cond    (cond_bits)
    );

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !stat_load_en) |=> ($stable(status_flags) && $stable(cond_bits))); // R10
    AST_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal && fire)); // R1
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (status_flags == 3'b000 && cond_bits == 4'b0000)); // R11
endmodule

// File: tb/addc_exec_unit_tb.sv
module addc_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr_word;
    logic        illegal;
    logic        gpr_load_en;
    logic [4:0]  gpr_load_idx;
    logic [31:0] gpr_load_data;
    logic        stat_load_en;
    logic [2:0]  stat_load_data;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic [2:0]  status_flags;
    logic [3:0]  cond_bits;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_gpr [32];
    logic [2:0]  m_flags;
    logic [3:0]  m_cond;

    always #10 clk = ~clk;

    addc_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .illegal(illegal), .gpr_load_en(gpr_load_en), .gpr_load_idx(gpr_load_idx),
        .gpr_load_data(gpr_load_data), .stat_load_en(stat_load_en),
        .stat_load_data(stat_load_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .status_flags(status_flags), .cond_bits(cond_bits)
    );

    function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic oe, input logic rc);
        return {6'd31, rt, ra, rb, oe, 9'd10, rc};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic preload(input logic [4:0] idx, input logic [31:0] val);
        @(negedge clk);
        gpr_load_en = 1; gpr_load_idx = idx; gpr_load_data = val;
        @(negedge clk);
        gpr_load_en = 0;
        m_gpr[idx] = val;
    endtask

    task automatic load_status(input logic [2:0] v);
        @(negedge clk);
        stat_load_en = 1; stat_load_data = v;
        @(negedge clk);
        stat_load_en = 0;
        m_flags = v;
        chk("R12 status preload", {29'd0, status_flags}, {29'd0, v});
    endtask

    // Apply one word at a negedge; model it; compare one edge later.
    task automatic run(input logic [31:0] w, input string tag);
        logic        ok;
        logic [4:0]  rt, ra, rb;
        logic        oe, rc, ca, ov, so;
        logic [32:0] wide;
        logic [31:0] res;
        ok = (w[31:26] == 6'd31) && (w[9:1] == 9'd10);
        rt = w[25:21]; ra = w[20:16]; rb = w[15:11]; oe = w[10]; rc = w[0];
        @(negedge clk);
        instr_valid = 1; instr_word = w; rd_idx = rt;
        #1;
        chk({tag, " R1/R10 illegal"}, {31'd0, illegal}, {31'd0, !ok});
        if (ok) begin
            wide = {1'b0, m_gpr[ra]} + {1'b0, m_gpr[rb]};
            res  = wide[31:0];
            ca   = wide[32];
            ov   = (m_gpr[ra][31] == m_gpr[rb][31]) && (res[31] != m_gpr[ra][31]);
            m_gpr[rt] = res;
            m_flags[0] = ca;
            if (oe) begin
                so = m_flags[2] | ov;
                m_flags[1] = ov;
                m_flags[2] = so;
            end
            if (rc)
                m_cond = {res[31], !res[31] && res != 0, res == 0, m_flags[2]};
        end
        @(negedge clk);
        instr_valid = 0;
        chk({tag, " R2/R10 target reg"}, rd_data, m_gpr[rt]);
        chk({tag, " R3/R4/R5/R6 flags"}, {29'd0, status_flags}, {29'd0, m_flags});
        chk({tag, " R7/R8/R9 cond"}, {28'd0, cond_bits}, {28'd0, m_cond});
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; instr_valid = 0; instr_word = 0;
        gpr_load_en = 0; gpr_load_idx = 0; gpr_load_data = 0;
        stat_load_en = 0; stat_load_data = 0; rd_idx = 0;
        repeat (3) @(negedge clk);
        chk("R11 reset flags", {29'd0, status_flags}, 32'd0);
        chk("R11 reset cond", {28'd0, cond_bits}, 32'd0);
        chk("R10 idle illegal low", {31'd0, illegal}, 32'd0);
        rst_n = 1;
        m_flags = 0; m_cond = 0;
        for (int i = 0; i < 32; i++) preload(5'(i), $urandom());
        rd_idx = 5'd9; #1;
        chk("R12 readback", rd_data, m_gpr[9]);

        // Directed corners
        preload(4, 32'h90003000); preload(10, 32'h80007000);
        run(mk(6, 4, 10, 0, 0), "dir1");
        chk("R2 dir1 sum", m_gpr[6], 32'h1000A000);
        chk("R3 dir1 carry", {31'd0, status_flags[0]}, 32'd1);
        preload(4, 32'h70003000); preload(10, 32'hFFFFFFFF);
        run(mk(6, 4, 10, 0, 1), "dir2");
        chk("R7 dir2 gt", {28'd0, cond_bits}, 32'h4);
        preload(4, 32'h90003000); preload(10, 32'h7B4192C0);
        run(mk(6, 4, 10, 1, 0), "dir3");
        chk("R4 dir3 ov clear", {29'd0, status_flags}, 32'h1);
        preload(4, 32'h80000000); preload(10, 32'h80007000);
        run(mk(6, 4, 10, 1, 1), "dir4");
        chk("R5 dir4 ov so set", {29'd0, status_flags}, 32'h7);
        chk("R8 dir4 cond so", {28'd0, cond_bits}, 32'h5);
        preload(1, 32'h00000001); preload(2, 32'h00000002);
        run(mk(3, 1, 2, 1, 1), "sticky");
        chk("R5 so stays", {29'd0, status_flags}, 32'h4);
        load_status(3'b000);
        preload(1, 32'hFFFFFFFF); preload(2, 32'h00000001);
        run(mk(3, 1, 2, 0, 1), "zero");
        chk("R7 eq", {28'd0, cond_bits}, 32'h2);
        preload(2, 32'hFFFFFFFE);
        run(mk(3, 1, 2, 0, 1), "neg");
        chk("R7 lt", {28'd0, cond_bits}, 32'h8);
        run(mk(3, 1, 2, 0, 0) ^ 32'h0400_0000, "badop");
        run(mk(3, 1, 2, 1, 1) ^ 32'h0000_0004, "badxo");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            w = mk(5'($urandom()), 5'($urandom()), 5'($urandom()), 1'($urandom()), 1'($urandom()));
            if (($urandom() % 8) == 0) w = w ^ (32'd1 << ($urandom() % 31 + 1));
            if (($urandom() % 16) == 0) preload(5'($urandom()), 32'h8000_0000 | $urandom());
            run(w, "rnd");
        end
        finish_run();
    end
endmodule